// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on an incoming master clock and measures how many master clock cycles fit into one period of an incoming word (frame) clock. It sorts each measured period into one of the supported oversampling ratios and publishes a ratio code for the filters that follow. It serves a receiver that takes both clocks from outside. When the receiver generates its own clocks, a configuration field supplies the ratio and this block is not used.

A parameter selects between two variants. The playback variant accepts 128, 192, 256, 384, 512 and 768 master clocks per sample. The capture variant accepts only 256, 384, 512 and 768. A count matches a ratio when it lies within a tolerance of ±32 clocks of the nominal value. A count that matches nothing selects 768. The word clock passes through a synchroniser, so phase drift and jitter between the two clocks are tolerated. A new ratio is taken only when two periods in a row agree. A stopped word clock forces the 768 setting.

Top module: `mclk_ratio_detect`

## Requirements
- R1: A period is the number of master clock cycles from one synchronised rising edge of the word clock to the next. A count of 96 is taken as 128 fs, and a count of 95 is out of range.
- R2: With LOW_RATES=1, a period within 32 clocks of 128, 192, 256, 384, 512 or 768 (bounds included) classifies to code 0, 1, 2, 3, 4 or 5 respectively.
- R3: With LOW_RATES=0, codes 0 and 1 are never produced. A period in the 128 or 192 window that lies outside every other window classifies to code 5.
- R4: A period more than 32 clocks away from every accepted ratio classifies to code 5 (768 fs), for example 289, 351, 417, 479 and 545.
- R5: Where two windows overlap, the smaller ratio wins. With LOW_RATES=1, 160 gives code 0 and 224 gives code 1. With LOW_RATES=0, 224 gives code 2.
- R6: The ratio output changes only when two consecutive measured periods give the same code. A single differing period leaves the output unchanged.
- R7: The period counter saturates at 801 (768+32+1) and never wraps. If the count reaches 801 with no rising edge seen, the output becomes code 5 with valid high at once. A period of exactly 800 is measured normally.
- R8: Reset sets the code to 5 and valid low. Valid rises with the first confirmed classification or forced default and stays high until the next reset.
- R9: The first rising edge after reset only starts a measurement. The partial interval before it is never classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Word clock, asynchronous in phase to mclk |
| ratio | output | 3 | Ratio code: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 fs |
| ratio_valid | output | 1 | High once a ratio has been confirmed or forced |

## Verification
A rising word clock edge and counter saturation can compete for the same cycle. The edge has priority, so a period of 800 is measured like any other, while a period of 801 lets saturation fire first and forces the default ratio without confirmation. The bench sets up a steady 256 fs stream and then inserts one period of 800 and, in a separate run, one period of 801. After the next edge it checks that the first leaves code 2 in place and the second shows code 5.

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter bit LOW_RATES = 1'b1,
  parameter int TOL       = 32
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       wclk,
  output logic [2:0] ratio,
  output logic       ratio_valid
);
  localparam int CNT_MAX = 768 + TOL + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [2:0] CODE_DEF = 3'd5;

  logic [2:0]    wsync;
  logic [CW-1:0] cnt;
  logic          armed, cand_ok;
  logic [2:0]    cand, cls;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) wsync <= '0;
    else        wsync <= {wsync[1:0], wclk};

  wire rise  = wsync[1] & ~wsync[2];
  wire stall = !rise && (cnt == CW'(CNT_MAX - 1));

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (rise) begin
      cnt   <= CW'(1);
      armed <= 1'b1;
    end else if (cnt != CW'(CNT_MAX)) begin
      cnt   <= cnt + CW'(1);
    end

  function automatic logic near(input logic [CW-1:0] c, input int nom);
    int v;
    v = int'(c);
    return (v >= nom - TOL) && (v <= nom + TOL);
  endfunction

  always_comb begin
    cls = CODE_DEF;
    if      (LOW_RATES && near(cnt, 128)) cls = 3'd0;
    else if (LOW_RATES && near(cnt, 192)) cls = 3'd1;
    else if (near(cnt, 256))              cls = 3'd2;
    else if (near(cnt, 384))              cls = 3'd3;
    else if (near(cnt, 512))              cls = 3'd4;
    else if (near(cnt, 768))              cls = 3'd5;
  end

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      cand        <= CODE_DEF;
      cand_ok     <= 1'b0;
      ratio       <= CODE_DEF;
      ratio_valid <= 1'b0;
    end else if (stall) begin
      cand        <= CODE_DEF;
      cand_ok     <= 1'b1;
      ratio       <= CODE_DEF;
      ratio_valid <= 1'b1;
    end else if (rise && armed) begin
      if (cand_ok && cls == cand) begin
        ratio       <= cls;
        ratio_valid <= 1'b1;
      end
      cand    <= cls;
      cand_ok <= 1'b1;
    end
endmodule

module mclk_ratio_detect_chk #(
  parameter bit LOW_RATES = 1'b1,
  parameter int CNT_MAX   = 801,
  parameter int CW        = 10
) (
  input logic          mclk,
  input logic          rst_n,
  input logic [2:0]    ratio,
  input logic          ratio_valid,
  input logic [CW-1:0] cnt,
  input logic          rise,
  input logic          stall
);
  assert_code_legal_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio <= 3'd5);

  assert_no_low_codes_R3: assert property (@(posedge mclk) disable iff (!rst_n)
    (LOW_RATES == 1'b0) |-> ratio >= 3'd2);

  assert_no_wrap_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    (cnt == CW'(CNT_MAX) && !rise) |=> cnt == CW'(CNT_MAX));

  assert_stall_default_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    stall |=> (ratio == 3'd5 && ratio_valid));

  assert_change_on_event_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(ratio) |-> $past(rise || stall));

  assert_valid_sticky_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_valid |=> ratio_valid);
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk #(
  .LOW_RATES(LOW_RATES), .CNT_MAX(CNT_MAX), .CW(CW)
) u_chk (
  .mclk(mclk), .rst_n(rst_n), .ratio(ratio), .ratio_valid(ratio_valid),
  .cnt(cnt), .rise(rise), .stall(stall)
);

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  // period, playback code, capture code
  localparam int VEC [0:NV-1][0:2] = '{
    '{ 96,0,5}, '{ 95,5,5}, '{128,0,5}, '{160,0,5}, '{161,1,5}, '{192,1,5},
    '{224,1,2}, '{225,2,2}, '{256,2,2}, '{288,2,2}, '{289,5,5}, '{351,5,5},
    '{352,3,3}, '{384,3,3}, '{416,3,3}, '{417,5,5}, '{479,5,5}, '{480,4,4},
    '{512,4,4}, '{544,4,4}, '{545,5,5}, '{736,5,5}, '{768,5,5}, '{800,5,5}
  };

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic wclk = 1'b0;
  logic [2:0] r_dac, r_adc;
  logic v_dac, v_adc;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  mclk_ratio_detect #(.LOW_RATES(1'b1)) u_dut (
    .mclk(mclk), .rst_n(rst_n), .wclk(wclk), .ratio(r_dac), .ratio_valid(v_dac));
  mclk_ratio_detect #(.LOW_RATES(1'b0)) u_dut_adc (
    .mclk(mclk), .rst_n(rst_n), .wclk(wclk), .ratio(r_adc), .ratio_valid(v_adc));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic period(input int p);
    wclk = 1'b1;
    repeat (p/2) @(negedge mclk);
    wclk = 1'b0;
    repeat (p - p/2) @(negedge mclk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wclk = 1'b0;
    repeat (4) @(negedge mclk);
    chk("R8 reset valid", int'(v_dac), 0);
    chk("R8 reset code", int'(r_dac), 5);
    chk("R8 reset valid capture", int'(v_adc), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R9: partial interval near 256 must not pair with the next period
    repeat (250) @(negedge mclk);
    period(256);
    period(256);
    chk("R9 first edge unmeasured", int'(v_dac), 0);
    period(256);
    chk("R6 confirm valid", int'(v_dac), 1);
    chk("R6 confirm code", int'(r_dac), 2);

    for (int i = 0; i < NV; i++) begin
      repeat (5) period(VEC[i][0]);
      chk($sformatf("R1 R2 R4 R5 playback P=%0d", VEC[i][0]), int'(r_dac), VEC[i][1]);
      chk($sformatf("R3 R4 R5 capture P=%0d", VEC[i][0]), int'(r_adc), VEC[i][2]);
      chk("R8 valid held", int'(v_dac & v_adc), 1);
    end

    // R6 single odd period ignored
    repeat (3) period(256);
    period(512);
    period(256);
    chk("R6 glitch ignored", int'(r_dac), 2);
    period(256);
    chk("R6 glitch ignored later", int'(r_dac), 2);

    // R7 edge wins at 800
    repeat (3) period(256);
    period(800);
    period(256);
    chk("R7 period 800 not forced", int'(r_dac), 2);
    chk("R7 period 800 not forced capture", int'(r_adc), 2);

    // R7 saturation at 801 forces default
    repeat (3) period(256);
    period(801);
    period(256);
    chk("R7 period 801 forced", int'(r_dac), 5);
    chk("R7 period 801 forced capture", int'(r_adc), 5);

    // R7 R8 stopped word clock from reset
    do_reset();
    repeat (900) @(negedge mclk);
    chk("R7 stall valid", int'(v_dac), 1);
    chk("R7 stall code", int'(r_dac), 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule